// File: doc/BRIEF.md
# Two-Stage Decimate-by-Eight FIR Chain

This block lowers the rate of a stream of 24-bit signed samples by eight. It runs two finite-impulse-response stages in series. The front stage keeps one result for every four samples it takes in. The back stage takes only the front stage's results and keeps one for every two of them. Each stage has a single multiplier and accumulator. After the last sample of each decimation group arrives, the stage walks its tap list one coefficient per clock.

Each stage can draw its coefficients from three sources, chosen by a two-bit mode input:
- a computed linear-phase set of fixed length (48 taps in front, 126 taps in back);
- a computed minimum-phase set of the same lengths;
- a per-stage writable table of up to 255 taps, with the tap count taken from a configuration input.

A change of mode restarts both stages with empty history. A sample that reaches a stage while it is still accumulating is lost, and a sticky flag records the loss.

Top module: `fir_chain_dec8`

## Requirements
- R1: The front stage emits one result per four samples it accepts. The back stage emits one result per two front-stage results it accepts. After a restart or reset, the first `out_valid` follows the eighth accepted input sample.
- R2: A stage result is y = sat(floor(sum over k<N of h(k)·x(n−k) / 2^23)). Here x(n) is the newest accepted sample and history before a reset or restart counts as zero. The saturation clamps to the range −8388608..8388607.
- R3: A sample that reaches a stage while that stage is accumulating is dropped and sets that stage's `ovf` bit (bit 0 front, bit 1 back). The bit stays set until reset or a mode change.
- R4: If a stage with N taps accepts the group-closing sample at clock edge E, its result is valid for exactly one cycle after edge E+N. The back stage accepts a front-stage result at the edge after that result appears.
- R5: `mode_sel` encodes 0 linear-phase, 1 minimum-phase, 2 programmed. Value 3 behaves exactly as 0.
- R6: The linear-phase set of length L has h(k) = min(k+1, L−k)·floor(8388607/S). S is the sum of min(k+1, L−k) over all k<L.
- R7: The minimum-phase set of length L has h(k) = (L−k)·floor(8388607/(L(L+1)/2)).
- R8: In programmed mode a stage uses N = `cfg_taps1` or `cfg_taps2`, captured at reset or at a mode change, with 0 treated as 1. The built-in modes use 48 and 126 taps and ignore these inputs.
- R9: When `coef_we` is high, `coef_data` is stored at tap `coef_addr` (0..254) of the stage chosen by `coef_stage` (0 front, 1 back). Address 255 is ignored, and writes are ignored while the active mode is programmed. The table is zeroed by reset.
- R10: A change of `mode_sel` takes one cycle. In that cycle the input is dropped, and history, phase, pending work, `out_valid`, `out_data` and `ovf` of both stages are cleared.
- R11: During and after reset `out_valid`, `out_data` and `ovf` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Coefficient source selection |
| cfg_taps1 | input | 8 | Front-stage tap count for programmed mode |
| cfg_taps2 | input | 8 | Back-stage tap count for programmed mode |
| coef_we | input | 1 | Coefficient write strobe |
| coef_stage | input | 1 | Stage chosen for the write |
| coef_addr | input | 8 | Tap index for the write |
| coef_data | input | 24 | Signed coefficient value |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 24 | Signed input sample |
| out_valid | output | 1 | Decimated result strobe |
| out_data | output | 24 | Signed decimated result |
| ovf | output | 2 | Sticky dropped-sample flags, bit 0 front, bit 1 back |

## Verification
A wrong history pointer or a stale coefficient in either stage changes the next `out_data` value, so it shows up at most one decimated output later. A wrong phase counter or tap counter moves `out_valid` by whole cycles. Because the reference predicts the exact edge of every strobe, such an error is seen in the first output after it occurs. A busy flag that clears too early or too late shows up either as a spurious `ovf` bit in the cycle of the colliding sample, or as a missing one.

// File: rtl/fir_chain_pkg.sv
package fir_chain_pkg;

    localparam int DATA_W   = 24;
    localparam int COEF_W   = 24;
    localparam int FRAC_W   = 23;
    localparam int PROD_W   = DATA_W + COEF_W;
    localparam int MAX_TAPS = 255;
    localparam int TAP_AW   = 8;
    localparam int ACC_W    = PROD_W + TAP_AW;

    typedef enum logic [1:0] {
        SRC_LIN  = 2'd0,
        SRC_MIN  = 2'd1,
        SRC_PROG = 2'd2,
        SRC_LIN2 = 2'd3
    } coef_src_e;

    typedef struct packed {
        logic                     vld;
        logic signed [DATA_W-1:0] data;
    } smp_t;

    function automatic int lin_weight(input int k, input int len);
        return (k + 1 < len - k) ? k + 1 : len - k;
    endfunction

    function automatic int lin_step(input int len);
        int sum;
        sum = 0;
        for (int k = 0; k < len; k++) sum += lin_weight(k, len);
        return 8388607 / sum;
    endfunction

    function automatic int min_step(input int len);
        return 8388607 / ((len * (len + 1)) / 2);
    endfunction

    function automatic logic signed [DATA_W-1:0] scale_sat(input logic signed [ACC_W-1:0] acc);
        logic signed [ACC_W-1:0] sh;
        sh = acc >>> FRAC_W;
        if (sh > $signed(ACC_W'(8388607)))       return 24'sh7FFFFF;
        else if (sh < -$signed(ACC_W'(8388608))) return 24'sh800000;
        else                                     return sh[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/fir_coef_bank.sv
module fir_coef_bank
    import fir_chain_pkg::*;
#(
    parameter int BUILTIN_LEN = 48
) (
    input  logic                     clk,
    input  logic                     rst,
    input  coef_src_e                src,
    input  logic                     wr_en,
    input  logic [TAP_AW-1:0]        wr_addr,
    input  logic signed [COEF_W-1:0] wr_data,
    input  logic [TAP_AW-1:0]        rd_addr,
    output logic signed [COEF_W-1:0] rd_coef
);
    localparam int LSTEP = lin_step(BUILTIN_LEN);
    localparam int MSTEP = min_step(BUILTIN_LEN);

    logic signed [COEF_W-1:0] lin_rom [BUILTIN_LEN];
    logic signed [COEF_W-1:0] min_rom [BUILTIN_LEN];
    logic signed [COEF_W-1:0] prog_ram [MAX_TAPS];

    for (genvar i = 0; i < BUILTIN_LEN; i++) begin : g_rom
        assign lin_rom[i] = COEF_W'(lin_weight(i, BUILTIN_LEN) * LSTEP);
        assign min_rom[i] = COEF_W'((BUILTIN_LEN - i) * MSTEP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MAX_TAPS; i++) prog_ram[i] <= '0;
        end else if (wr_en && (int'(wr_addr) < MAX_TAPS)) begin
            prog_ram[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        rd_coef = '0;
        if (src == SRC_PROG) begin
            if (int'(rd_addr) < MAX_TAPS) rd_coef = prog_ram[rd_addr];
        end else if (int'(rd_addr) < BUILTIN_LEN) begin
            rd_coef = (src == SRC_MIN) ? min_rom[rd_addr] : lin_rom[rd_addr];
        end
    end

endmodule

// File: rtl/fir_dec_stage.sv
module fir_dec_stage
    import fir_chain_pkg::*;
#(
    parameter int DEC         = 4,
    parameter int BUILTIN_LEN = 48
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     restart,
    input  coef_src_e                src_new,
    input  coef_src_e                src_act,
    input  logic [TAP_AW-1:0]        cfg_taps,
    input  logic                     wr_en,
    input  logic [TAP_AW-1:0]        wr_addr,
    input  logic signed [COEF_W-1:0] wr_data,
    input  smp_t                     in_s,
    output smp_t                     out_s,
    output logic                     ovf
);
    localparam int PH_W = (DEC > 1) ? $clog2(DEC) : 1;

    logic signed [DATA_W-1:0] hist [MAX_TAPS];
    logic [TAP_AW-1:0]        head, head_nxt, kidx, ntaps, rd_idx;
    logic [PH_W-1:0]          phase;
    logic                     busy, accept, last_tap;
    logic [TAP_AW:0]          diff;
    logic signed [ACC_W-1:0]  acc, acc_nxt;
    logic signed [PROD_W-1:0] prod;
    logic signed [COEF_W-1:0] coef;

    fir_coef_bank #(.BUILTIN_LEN(BUILTIN_LEN)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .src    (src_act),
        .wr_en  (wr_en && (src_act != SRC_PROG)),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(kidx),
        .rd_coef(coef)
    );

    assign head_nxt = (int'(head) == MAX_TAPS - 1) ? '0 : head + 1'b1;
    assign diff     = {1'b0, head} - {1'b0, kidx};
    assign rd_idx   = diff[TAP_AW] ? TAP_AW'(diff + (TAP_AW + 1)'(MAX_TAPS)) : diff[TAP_AW-1:0];
    assign prod     = coef * hist[rd_idx];
    assign acc_nxt  = acc + ACC_W'(prod);
    assign accept   = in_s.vld && !busy;
    assign last_tap = (kidx == ntaps - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            for (int i = 0; i < MAX_TAPS; i++) hist[i] <= '0;
            head  <= '0;
            phase <= '0;
            busy  <= 1'b0;
            kidx  <= '0;
            acc   <= '0;
            out_s <= '0;
            ovf   <= 1'b0;
            if (src_new == SRC_PROG) ntaps <= (cfg_taps == '0) ? TAP_AW'(1) : cfg_taps;
            else                     ntaps <= TAP_AW'(BUILTIN_LEN);
        end else begin
            out_s.vld <= 1'b0;
            if (in_s.vld && busy) ovf <= 1'b1;
            if (accept) begin
                hist[head_nxt] <= in_s.data;
                head           <= head_nxt;
                if (phase == PH_W'(DEC - 1)) begin
                    phase <= '0;
                    busy  <= 1'b1;
                    kidx  <= '0;
                    acc   <= '0;
                end else begin
                    phase <= phase + 1'b1;
                end
            end
            if (busy) begin
                if (last_tap) begin
                    busy       <= 1'b0;
                    out_s.vld  <= 1'b1;
                    out_s.data <= scale_sat(acc_nxt);
                end else begin
                    kidx <= kidx + 1'b1;
                    acc  <= acc_nxt;
                end
            end
        end
    end

endmodule

// File: rtl/fir_chain_dec8.sv
module fir_chain_dec8
    import fir_chain_pkg::*;
#(
    parameter int DEC1 = 4,
    parameter int DEC2 = 2,
    parameter int LEN1 = 48,
    parameter int LEN2 = 126
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  mode_sel,
    input  logic [7:0]  cfg_taps1,
    input  logic [7:0]  cfg_taps2,
    input  logic        coef_we,
    input  logic        coef_stage,
    input  logic [7:0]  coef_addr,
    input  logic [23:0] coef_data,
    input  logic        in_valid,
    input  logic [23:0] in_data,
    output logic        out_valid,
    output logic [23:0] out_data,
    output logic [1:0]  ovf
);
    coef_src_e src_act, src_new;
    logic      restart;
    smp_t      s0_in, s1_out, s2_out;

    assign src_new = coef_src_e'(mode_sel);
    assign restart = !rst && (src_new != src_act);
    assign s0_in   = '{vld: in_valid, data: in_data};

    always_ff @(posedge clk) begin
        if (rst || restart) src_act <= src_new;
    end

    fir_dec_stage #(.DEC(DEC1), .BUILTIN_LEN(LEN1)) u_front (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .src_new (src_new),
        .src_act (src_act),
        .cfg_taps(cfg_taps1),
        .wr_en   (coef_we && !coef_stage),
        .wr_addr (coef_addr),
        .wr_data (coef_data),
        .in_s    (s0_in),
        .out_s   (s1_out),
        .ovf     (ovf[0])
    );

    fir_dec_stage #(.DEC(DEC2), .BUILTIN_LEN(LEN2)) u_back (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .src_new (src_new),
        .src_act (src_act),
        .cfg_taps(cfg_taps2),
        .wr_en   (coef_we && coef_stage),
        .wr_addr (coef_addr),
        .wr_data (coef_data),
        .in_s    (s1_out),
        .out_s   (s2_out),
        .ovf     (ovf[1])
    );

    assign out_valid = s2_out.vld;
    assign out_data  = s2_out.data;

endmodule

// File: rtl/fir_chain_chk.sv
module fir_chain_chk (
    input logic       clk,
    input logic       rst,
    input logic       restart,
    input logic       s1_valid,
    input logic       out_valid,
    input logic [1:0] ovf,
    input logic [23:0] out_data
);
    logic rst_q = 1'b0;

    always_ff @(posedge clk) rst_q <= rst;

    always_comb begin
        if (rst_q) begin
            AST_RESET_CLEAR: assert (!out_valid && ovf == 2'b00 && out_data == 24'd0); // R11
        end
    end

    AST_OUT_PULSE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R1

    AST_FRONT_PULSE: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> !s1_valid); // R4

    AST_OVF_HOLD_FRONT: assert property (@(posedge clk) disable iff (rst)
        (ovf[0] && !restart) |=> ovf[0]); // R3

    AST_OVF_HOLD_BACK: assert property (@(posedge clk) disable iff (rst)
        (ovf[1] && !restart) |=> ovf[1]); // R3

    AST_OVF_BACK_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf[1]) |-> $past(s1_valid)); // R3

    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!out_valid && !s1_valid && ovf == 2'b00)); // R10

endmodule

bind fir_chain_dec8 fir_chain_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .s1_valid (s1_out.vld),
    .out_valid(out_valid),
    .ovf      (ovf),
    .out_data (out_data)
);

// File: tb/fir_chain_dec8_tb_top.sv
`timescale 1ns/1ps
module fir_chain_dec8_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_sel = 2'd0;
    logic [7:0]  cfg_taps1 = 8'd0, cfg_taps2 = 8'd0;
    logic        coef_we = 1'b0, coef_stage = 1'b0;
    logic [7:0]  coef_addr = 8'd0;
    logic [23:0] coef_data = 24'd0;
    logic        in_valid = 1'b0;
    logic [23:0] in_data = 24'd0;
    logic        out_valid;
    logic [23:0] out_data;
    logic [1:0]  ovf;

    always #2 clk = ~clk;

    fir_chain_dec8 dut_i (.*);

    int checks = 0, errors = 0;
    int edge_n = 0;
    string cur_req = "R2";

    int hq [2][$];
    int cust [2][255];
    int busy_until [2], phase [2], ntaps [2];
    int ovf_m [2];
    int act_mode;
    int s1p_edge, s1p_val;
    int exp_edge [$], exp_val [$];
    int n_out = 0;
    int seed = 12345;

    function automatic int lstep(int len);
        int s = 0;
        for (int k = 0; k < len; k++) s += ((k + 1 < len - k) ? k + 1 : len - k);
        return 8388607 / s;
    endfunction

    function automatic int coef_of(int s, int k);
        int len = (s == 0) ? 48 : 126;
        if (act_mode == 2) return cust[s][k];
        if (k >= len) return 0;
        if (act_mode == 1) return (len - k) * (8388607 / ((len * (len + 1)) / 2)); // R7
        return ((k + 1 < len - k) ? k + 1 : len - k) * lstep(len);                 // R6, R5
    endfunction

    function automatic int clamp(longint v);
        if (v > 8388607) return 8388607;
        if (v < -8388608) return -8388608;
        return int'(v);
    endfunction

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 8) % 8388608;
    endfunction

    task automatic capture_taps();
        for (int s = 0; s < 2; s++) begin
            int c = (s == 0) ? int'(cfg_taps1) : int'(cfg_taps2);
            if (act_mode == 2) ntaps[s] = (c == 0) ? 1 : c;                          // R8
            else               ntaps[s] = (s == 0) ? 48 : 126;
        end
    endtask

    task automatic clear_model();
        for (int s = 0; s < 2; s++) begin
            hq[s].delete(); busy_until[s] = -1; phase[s] = 0; ovf_m[s] = 0;
        end
        s1p_edge = -10; exp_edge.delete(); exp_val.delete();
        act_mode = int'(mode_sel);
        capture_taps();
    endtask

    task automatic accept(int s, int x, int e);
        if (e <= busy_until[s]) begin ovf_m[s] = 1; return; end
        hq[s].push_front(x);
        if (hq[s].size() > 255) void'(hq[s].pop_back());
        phase[s]++;
        if (phase[s] == ((s == 0) ? 4 : 2)) begin
            longint acc = 0;
            int y;
            phase[s] = 0;
            for (int k = 0; k < ntaps[s]; k++)
                if (k < hq[s].size()) acc += longint'(coef_of(s, k)) * longint'(hq[s][k]);
            y = clamp(acc >>> 23);
            busy_until[s] = e + ntaps[s];
            if (s == 0) begin s1p_edge = e + ntaps[0]; s1p_val = y; end
            else begin exp_edge.push_back(e + ntaps[1]); exp_val.push_back(y); end
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            clear_model();
            for (int s = 0; s < 2; s++) for (int k = 0; k < 255; k++) cust[s][k] = 0;
            return;
        end
        if (int'(mode_sel) != act_mode) begin clear_model(); return; end           // R10
        if (coef_we && coef_addr < 8'd255 && act_mode != 2)                        // R9
            cust[coef_stage][coef_addr] = $signed(coef_data);
        if (s1p_edge == edge_n - 1) accept(1, s1p_val, edge_n);
        if (in_valid) accept(0, $signed(in_data), edge_n);
    endtask

    task automatic compare();
        bit ev;
        while (exp_edge.size() > 0 && exp_edge[0] < edge_n) begin
            void'(exp_edge.pop_front()); void'(exp_val.pop_front());
        end
        ev = exp_edge.size() > 0 && exp_edge[0] == edge_n;
        checks++;
        if (out_valid !== ev) begin
            errors++;
            $display("FAIL R1/R4 out_valid edge %0d got %0b exp %0b", edge_n, out_valid, ev);
        end
        if (ev) begin
            int want = exp_val.pop_front();
            void'(exp_edge.pop_front());
            n_out++;
            checks++;
            if ($signed(out_data) !== want) begin
                errors++;
                $display("FAIL %s out_data edge %0d got %0d exp %0d", cur_req, edge_n, $signed(out_data), want);
            end
        end
        checks++;
        if (ovf !== {ovf_m[1][0], ovf_m[0][0]}) begin
            errors++;
            $display("FAIL R3 ovf edge %0d got %b exp %b", edge_n, ovf, {ovf_m[1][0], ovf_m[0][0]});
        end
    endtask

    task automatic tick();
        @(posedge clk);
        edge_n++;
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic send(int x, int gap);
        in_valid = 1'b1; in_data = 24'(x);
        tick();
        in_valid = 1'b0;
        repeat (gap - 1) tick();
    endtask

    task automatic wr(int s, int a, int d);
        coef_we = 1'b1; coef_stage = s[0]; coef_addr = 8'(a); coef_data = 24'(d);
        tick();
        coef_we = 1'b0;
    endtask

    task automatic set_mode(int m);
        mode_sel = 2'(m);
        tick();
    endtask

    task automatic expect_count(int want, string req);
        checks++;
        if (n_out != want) begin
            errors++;
            $display("FAIL %s output count got %0d exp %0d", req, n_out, want);
        end
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired at edge %0d", edge_n);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        checks++;                                                                  // R11
        if (out_valid !== 1'b0 || out_data !== 24'd0 || ovf !== 2'b00) begin
            errors++;
            $display("FAIL R11 reset state got %b/%h/%b exp 0/000000/00", out_valid, out_data, ovf);
        end

        cur_req = "R6";
        n_out = 0;
        send(8388607, 50);
        for (int i = 0; i < 47; i++) send((i % 8 == 3) ? 0 : rnd(), 50);
        repeat (200) tick();
        expect_count(6, "R1");

        cur_req = "R7";
        set_mode(1);
        n_out = 0;
        for (int i = 0; i < 24; i++) send((i % 2) ? 8000000 : -7000000, 50);
        repeat (200) tick();
        expect_count(3, "R1");

        cur_req = "R9";
        wr(0, 0, 8388607); wr(0, 1, 4194304); wr(0, 2, -2097152); wr(0, 3, 1000); wr(0, 4, 8388607);
        wr(1, 0, 8388607); wr(1, 1, 8388607); wr(1, 2, -100000);
        wr(0, 255, -5);
        cfg_taps1 = 8'd5; cfg_taps2 = 8'd3;
        cur_req = "R8";
        set_mode(2);
        for (int i = 0; i < 32; i++) send((i < 16) ? 8388607 : -8388608, 12);      // R2 saturation
        repeat (20) tick();
        cur_req = "R9";
        wr(0, 0, -8388608);
        for (int i = 0; i < 16; i++) send(rnd(), 12);
        repeat (20) tick();

        cur_req = "R3";
        for (int i = 0; i < 12; i++) send(rnd() - 4000000, 1);
        repeat (30) tick();
        cur_req = "R10";
        set_mode(0);
        for (int i = 0; i < 8; i++) send(rnd(), 50);
        repeat (200) tick();

        cur_req = "R3";
        cfg_taps1 = 8'd1; cfg_taps2 = 8'd20;
        set_mode(2);
        for (int i = 0; i < 24; i++) send(rnd(), 2);
        repeat (40) tick();

        cur_req = "R8";
        cfg_taps1 = 8'd0; cfg_taps2 = 8'd0;
        set_mode(1);
        set_mode(2);
        for (int i = 0; i < 16; i++) send(rnd(), 4);
        repeat (20) tick();

        cur_req = "R5";
        set_mode(3);
        n_out = 0;
        for (int i = 0; i < 16; i++) send(rnd() - 3000000, 50);
        repeat (200) tick();
        expect_count(2, "R5");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule